// File: doc/BRIEF.md
# Serial Converter Read Master

This block is the host end of a three-wire link to a 12-bit sampling converter. When it gets a start request it pulls the select line low and toggles the serial clock. The serial clock comes from the system clock through a programmable half-period. The block shifts in the returned word and presents the result in straight binary. The converter moves each bit out on a falling serial clock edge. The host takes each bit on the following falling edge, so the host's samples are one edge behind the converter's launches. A frame word is made of a zero prefix, the data bits with the most significant first, and one trailing slot that the host does not use.

The same start request can be given with a shutdown request. In that case the master deliberately cuts the frame short and raises select after the fourth falling edge. This puts the converter into its low-power state, and the block then reports that the converter is powered down. A converter that has just woken up, or has just been powered, gives one unusable conversion first. The master tracks this and quietly drops that first word. After every frame, select is held high for a programmable recovery interval, which has a floor, before a new start is accepted.

Top module: `sadc_host`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n and sclk are 1, and busy, result_valid, frame_err and powered_down are 0.
- R2: A start in idle drives cs_n low in the next cycle. sclk then stays high for H system cycles, where H is clk_div and a value of 0 counts as 1. It then runs 16 periods, each H cycles low followed by H cycles high. cs_n rises right after the 16th high half, so cs_n is low for 33*H cycles.
- R3: sdata is sampled in the cycle where sclk falls. The samples from falls 1 to 3 are the prefix and must all be 0. Falls 4 to 15 give result[11] down to result[0]. The level seen at fall 16 is ignored.
- R4: result_valid is a one-cycle pulse in the cycle where cs_n rises at the end of a good full frame. result keeps its value until the next such pulse.
- R5: If any prefix sample is 1, frame_err pulses for one cycle in place of result_valid, and result is unchanged.
- R6: A start given together with shutdown_req=1 gives only 4 sclk falls. cs_n is low for 9*H cycles. powered_down becomes 1 in the cycle where cs_n rises. Neither result_valid nor frame_err pulses.
- R7: The first full frame after reset, and the first full frame after a power-down frame, give neither result_valid nor frame_err. powered_down clears as that frame's cs_n rises. The next full frame is reported as normal.
- R8: After cs_n rises, busy stays high for R more cycles, where R = max(idle_cycles, 2). In total busy is high for the cs_n low time plus R, and cs_n is high for at least R+1 cycles between frames.
- R9: A start while busy is ignored: the frame in progress keeps its length and no extra frame follows.
- R10: shutdown_req without start changes nothing: cs_n stays high and powered_down keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame (taken only when idle) |
| shutdown_req | input | 1 | With start: run a short power-down frame |
| clk_div | input | DIV_W | sclk half-period in system cycles (0 acts as 1) |
| idle_cycles | input | IDLE_W | Recovery length after a frame (floor of 2) |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Serial clock, idles high |
| result | output | DATA_W | Last good conversion, straight binary |
| result_valid | output | 1 | One-cycle pulse on a new result |
| frame_err | output | 1 | One-cycle pulse on a bad prefix |
| busy | output | 1 | Frame or recovery in progress |
| powered_down | output | 1 | Converter left in low-power state |

## Verification
Several outcomes are decided on the same edge as cs_n rising at the end of a frame: the result pulse, a framing error, and the change of powered_down. The hardest case is the wake-up frame that follows a power-down frame. There, powered_down must fall on that edge while result_valid stays low, and the word must be dropped. The bench provokes this by issuing shutdown, wake and normal frames back to back, and between them it flips the prefix bits and the divider. A second collision is a start arriving while the sequencer is busy. The bench fires it in the middle of a frame and judges it by the fall count, the cs_n low time and the busy length, which must be those of a single frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_RECOV
    } phase_t;

    typedef struct packed {
        logic trunc;   // short frame that parks the converter
        logic dummy;   // word of this frame is thrown away
    } frame_mode_t;

endpackage

// File: rtl/sadc_half_timer.sv
module sadc_half_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] half,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    // a half-period of zero behaves as one cycle
    assign reload = (half == '0) ? '0 : half - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= reload;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int FRAME_FALLS = 16,
    parameter int SHDN_FALLS  = 4,
    parameter int CAP_BITS    = 15,
    parameter int IDLE_W      = 8,
    parameter int MIN_CS_HI   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              shutdown_req,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic              expire,
    output logic              load,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic              cap_en,
    output logic              done,
    output logic              discard,
    output logic              powered_down
);
    localparam int FW = $clog2(FRAME_FALLS + 1);
    localparam logic [FW-1:0]     LAST_FULL = FW'(FRAME_FALLS);
    localparam logic [FW-1:0]     LAST_SHDN = FW'(SHDN_FALLS);
    localparam logic [FW-1:0]     CAP_LIM   = FW'(CAP_BITS);
    localparam logic [IDLE_W-1:0] MIN_HI    = IDLE_W'((MIN_CS_HI < 1) ? 1 : MIN_CS_HI);

    phase_t            ph;
    frame_mode_t       mode;
    logic [FW-1:0]     falls;
    logic [IDLE_W-1:0] rec;
    logic              pd_q;
    logic              need_dummy;

    logic [FW-1:0]     end_falls;
    logic [IDLE_W-1:0] rec_len;
    logic              accept, go_low, go_high, finish;

    assign end_falls = mode.trunc ? LAST_SHDN : LAST_FULL;
    assign rec_len   = (idle_cycles < MIN_HI) ? MIN_HI : idle_cycles;

    assign accept  = (ph == PH_IDLE) && start;
    assign go_low  = expire && ((ph == PH_SETUP) || ((ph == PH_HIGH) && (falls != end_falls)));
    assign go_high = expire && (ph == PH_LOW);
    assign finish  = expire && (ph == PH_HIGH) && (falls == end_falls);

    assign load    = accept || go_low || go_high;
    assign cap_en  = go_low && (falls < CAP_LIM);
    assign done    = finish && !mode.trunc;
    assign discard = mode.dummy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            mode       <= '0;
            falls      <= '0;
            rec        <= '0;
            pd_q       <= 1'b0;
            need_dummy <= 1'b1;   // first conversion after power-up is unusable
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph    <= PH_SETUP;
                    falls <= '0;
                    mode  <= '{trunc: shutdown_req, dummy: need_dummy};
                end
                PH_SETUP: if (go_low) begin
                    ph    <= PH_LOW;
                    falls <= falls + 1'b1;
                end
                PH_LOW: if (go_high) ph <= PH_HIGH;
                PH_HIGH: begin
                    if (go_low) begin
                        ph    <= PH_LOW;
                        falls <= falls + 1'b1;
                    end else if (finish) begin
                        ph         <= PH_RECOV;
                        rec        <= rec_len - 1'b1;
                        pd_q       <= mode.trunc;
                        need_dummy <= mode.trunc;
                    end
                end
                PH_RECOV: begin
                    if (rec == '0) ph <= PH_IDLE;
                    else           rec <= rec - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign cs_n         = (ph == PH_IDLE) || (ph == PH_RECOV);
    assign sclk         = (ph != PH_LOW);
    assign busy         = (ph != PH_IDLE);
    assign powered_down = pd_q;

    AST_FALLS_BOUND: assert property (@(posedge clk) disable iff (rst)
        falls <= LAST_FULL);                                                    // R2
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !$past(busy));                                          // R9
    AST_PD_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(powered_down) |-> $rose(cs_n));                                   // R6

endmodule

// File: rtl/sadc_shift_cap.sv
module sadc_shift_cap #(
    parameter int LEAD_W = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              sdata,
    input  logic              done,
    input  logic              discard,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              frame_err
);
    localparam int CW = LEAD_W + DATA_W;

    logic [CW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (cap_en)
            sh <= {sh[CW-2:0], sdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_valid <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            frame_err    <= 1'b0;
            if (done && !discard) begin
                if (sh[CW-1 -: LEAD_W] == '0) begin
                    result       <= sh[DATA_W-1:0];
                    result_valid <= 1'b1;
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));                                     // R4

endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_W      = 3,
    parameter int FRAME_FALLS = 16,
    parameter int SHDN_FALLS  = 4,
    parameter int DIV_W       = 8,
    parameter int IDLE_W      = 8,
    parameter int MIN_CS_HI   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              shutdown_req,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic              sdata,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              frame_err,
    output logic              busy,
    output logic              powered_down
);
    localparam int CAP_BITS = LEAD_W + DATA_W;

    logic load, expire, cap_en, done, discard;

    sadc_half_timer #(.W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .half   (clk_div),
        .expire (expire)
    );

    sadc_frame_seq #(
        .FRAME_FALLS (FRAME_FALLS),
        .SHDN_FALLS  (SHDN_FALLS),
        .CAP_BITS    (CAP_BITS),
        .IDLE_W      (IDLE_W),
        .MIN_CS_HI   (MIN_CS_HI)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .shutdown_req (shutdown_req),
        .idle_cycles  (idle_cycles),
        .expire       (expire),
        .load         (load),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .busy         (busy),
        .cap_en       (cap_en),
        .done         (done),
        .discard      (discard),
        .powered_down (powered_down)
    );

    sadc_shift_cap #(.LEAD_W(LEAD_W), .DATA_W(DATA_W)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .cap_en       (cap_en),
        .sdata        (sdata),
        .done         (done),
        .discard      (discard),
        .result       (result),
        .result_valid (result_valid),
        .frame_err    (frame_err)
    );

    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $rose(cs_n));                                          // R4
    AST_ERR_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $rose(cs_n));                                             // R5
    AST_NO_VALID_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> !$past(powered_down));                                 // R7

endmodule

// File: tb/sim_sadc_host.sv
module sim_sadc_host;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        shutdown_req = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic [7:0]  idle_cycles = 8'd0;
    logic        sdata = 1'b1;
    logic        cs_n, sclk, result_valid, frame_err, busy, powered_down;
    logic [11:0] result;

    sadc_host u0 (
        .clk(clk), .rst(rst), .start(start), .shutdown_req(shutdown_req),
        .clk_div(clk_div), .idle_cycles(idle_cycles), .sdata(sdata),
        .cs_n(cs_n), .sclk(sclk), .result(result), .result_valid(result_valid),
        .frame_err(frame_err), .busy(busy), .powered_down(powered_down)
    );

    always #10 clk = ~clk;   // 50 MHz

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // converter model: launches a new bit after each observed sclk fall
    logic [15:0] word = '0;
    int   idx = 0;
    logic prev_cs = 1'b1, prev_sc = 1'b1;
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            idx = 0;
            sdata <= word[15];
        end else if (!cs_n && prev_sc && !sclk) begin
            idx = idx + 1;
            sdata <= (idx < 16) ? word[15-idx] : 1'b0;
        end else if (cs_n) begin
            sdata <= 1'b1;
        end
        prev_cs = cs_n;
        prev_sc = sclk;
    end

    // monitor
    int m_cslow, m_falls, m_busy, m_valid, m_err, m_setup, m_valid_cs;
    logic mon_sc = 1'b1;
    always @(negedge clk) begin
        if (!cs_n) m_cslow++;
        if (!cs_n && mon_sc && !sclk) m_falls++;
        if (!cs_n && sclk && m_falls == 0) m_setup++;
        if (busy) m_busy++;
        if (result_valid) begin m_valid++; m_valid_cs = int'(cs_n); end
        if (frame_err) m_err++;
        mon_sc = sclk;
    end

    task automatic clear_mon();
        m_cslow = 0; m_falls = 0; m_busy = 0; m_valid = 0; m_err = 0; m_setup = 0; m_valid_cs = 1;
    endtask

    // reference state
    bit          ref_pd = 1'b0;
    bit          ref_dummy = 1'b1;
    logic [11:0] ref_result = '0;

    task automatic do_frame(input logic [2:0] lead, input logic [11:0] data, input bit shdn,
                            input int h, input int idle, input bit poke);
        int he, s, exp_low, rec;
        bit exp_v, exp_e;
        he = (h == 0) ? 1 : h;
        s  = shdn ? 4 : 16;
        exp_low = he * (1 + 2*s);
        rec = (idle < 2) ? 2 : idle;
        word = {lead, data, 1'b0};
        clk_div = 8'(h);
        idle_cycles = 8'(idle);
        @(negedge clk);
        clear_mon();
        start = 1'b1;
        shutdown_req = shdn;
        @(negedge clk);
        start = 1'b0;
        shutdown_req = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            shutdown_req = 1'b1;
            @(negedge clk);
            start = 1'b0;
            shutdown_req = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        exp_v = 1'b0; exp_e = 1'b0;
        if (shdn) begin
            ref_pd = 1'b1; ref_dummy = 1'b1;
        end else if (ref_dummy) begin
            ref_pd = 1'b0; ref_dummy = 1'b0;
        end else if (lead != 3'b000) begin
            exp_e = 1'b1;
        end else begin
            exp_v = 1'b1; ref_result = data;
        end
        chk(shdn ? "R6" : "R2", "cs_n low cycles", m_cslow, exp_low);
        chk(shdn ? "R6" : "R2", "sclk falls", m_falls, s);
        chk("R2", "setup cycles", m_setup, he);
        chk("R8", "busy cycles", m_busy, exp_low + rec);
        chk(shdn ? "R6" : "R7", "valid pulses", m_valid, int'(exp_v));
        chk("R5", "error pulses", m_err, int'(exp_e));
        chk("R3", "result", int'(result), int'(ref_result));
        chk("R6", "powered_down", int'(powered_down), int'(ref_pd));
        if (exp_v) chk("R4", "cs_n at valid", m_valid_cs, 1);
        if (poke) chk("R9", "no extra frame", int'(cs_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5ADC));
        repeat (3) @(negedge clk);
        chk("R1", "cs_n in reset", int'(cs_n), 1);
        chk("R1", "sclk in reset", int'(sclk), 1);
        chk("R1", "busy in reset", int'(busy), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(result_valid), 0);
        chk("R1", "err after reset", int'(frame_err), 0);
        chk("R1", "powered_down after reset", int'(powered_down), 0);

        do_frame(3'b000, 12'hABC, 1'b0, 2, 0, 1'b0);   // R7 first frame dropped
        do_frame(3'b000, 12'hABC, 1'b0, 2, 0, 1'b0);   // R3 R4
        do_frame(3'b001, 12'h123, 1'b0, 1, 3, 1'b0);   // R5
        do_frame(3'b100, 12'h456, 1'b0, 3, 5, 1'b0);   // R5
        do_frame(3'b000, 12'hFFF, 1'b0, 0, 1, 1'b0);   // R2 div 0
        do_frame(3'b000, 12'h000, 1'b0, 1, 0, 1'b0);
        do_frame(3'b000, 12'h555, 1'b1, 2, 4, 1'b0);   // R6
        // R10: shutdown_req alone has no effect
        clear_mon();
        repeat (6) begin
            @(negedge clk);
            shutdown_req = ~shutdown_req;
        end
        shutdown_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10", "cs_n low cycles", m_cslow, 0);
        chk("R10", "powered_down held", int'(powered_down), 1);
        do_frame(3'b000, 12'h321, 1'b1, 1, 0, 1'b0);   // R6 while parked
        do_frame(3'b000, 12'h9A5, 1'b0, 1, 2, 1'b0);   // R7 wake frame dropped
        do_frame(3'b000, 12'h9A5, 1'b0, 1, 2, 1'b0);   // R7 next one valid
        do_frame(3'b000, 12'h777, 1'b0, 2, 3, 1'b1);   // R9

        for (int i = 0; i < 40; i++) begin
            logic [2:0] ld;
            ld = (($urandom % 5) == 0) ? 3'($urandom % 8) : 3'b000;
            do_frame(ld, 12'($urandom), (($urandom % 7) == 0), int'($urandom % 5),
                     int'($urandom % 7), (($urandom % 6) == 0));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule